// File: doc/BRIEF.md
# Time-Protected System Configuration Register

This block holds one 8-bit system configuration word behind a simple bus-slave port. The port has a select line from the address decoder, a write strobe, write data and read data. Each bit drives a control line to other parts of the chip: converter power, clock source choice, interrupt pin sensing, start-up delay, clock monitor enables and a two-bit rate field. The logic that acts on those lines lies outside the block. It only receives the bits.

Five of the bits are guarded. A guarded bit takes a value only during a short window after reset is released, and only from the first write made in that window. After that it is read-only until the next reset. A special-mode input lifts the guard, so every bit can then be written at any time. The three unguarded bits can always be written. The block also turns the raw active-low interrupt pin into an interrupt request. Which sensing it uses depends on the edge-select bit: in falling-edge mode a latched request is held until it is cleared, and in level mode the request follows a synchronized copy of the pin.

Top module: `sys_cfg_guard`

## Requirements
- R1: Register bits map as follows, bit 7 first. Bit 7 is converter power-up (`conv_pwr_en`), bit 6 is clock source select (`clk_src_rc`), bit 5 is interrupt falling-edge mode (`irq_fall_mode`), bit 4 is start-up delay enable, bit 3 is clock monitor enable (`clkmon_en`), bit 2 is fast clock monitor enable (`clkmon_fast`) and bits 1:0 are the rate field (`rate_sel`). Each output equals its bit.
- R2: After reset the word reads 8'h10, so only the start-up delay bit is set.
- R3: Guarded bits 5, 4, 2, 1 and 0 accept a write only while fewer than WINDOW (64) clock cycles have passed since reset release. A write in cycle 63 is accepted. A write in cycle 64 leaves the guarded bits unchanged.
- R4: Outside special mode, only the first write inside the window reaches the guarded bits. Later writes leave them as they are, until reset.
- R5: While `special_mode` is high, the guarded bits take every write, with no window and no write-once limit.
- R6: Bits 7, 6 and 3 take every write in any mode and at any time.
- R7: `startup_dly_req` equals bit 4, and `osc_bypass` is its inverse.
- R8: With bit 5 set, a falling edge on `irq_pin_n` sets `irq_req`. It stays set until `irq_clr` is sampled high, and it is seen 2 cycles after the pin is sampled low.
- R9: With bit 5 clear, `irq_req` is the inverse of the pin after a two-flop synchronizer. It rises on the second clock edge after the pin falls, and it falls in the same way after the pin rises.
- R10: `bus_rdata` always shows all 8 bits, whatever the lock state. A write strobe while `bus_sel` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | Lifts the guard on the protected bits |
| bus_sel | input | 1 | Register address decode hit |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, the full register |
| irq_pin_n | input | 1 | Raw active-low interrupt pin |
| irq_clr | input | 1 | Clears a latched edge request |
| conv_pwr_en | output | 1 | Converter power-up |
| clk_src_rc | output | 1 | Clock source select |
| irq_fall_mode | output | 1 | Interrupt falling-edge mode |
| startup_dly_req | output | 1 | Start-up stabilization delay requested |
| osc_bypass | output | 1 | Oscillator delay bypassed |
| clkmon_en | output | 1 | Clock monitor enable |
| clkmon_fast | output | 1 | Fast clock monitor enable |
| rate_sel | output | 2 | Rate field |
| irq_req | output | 1 | Interrupt request |

## Verification
Suppose the window counter or the lock flag is corrupted. The next write would then change a guarded bit when it should not, or keep one it should take. Either fault shows up on `bus_rdata` and on the decoded outputs one cycle after that write, so every write is followed by a readback. The window edge is probed at exactly cycles 63 and 64 after reset release. A fault in the interrupt path shows on `irq_req` within two to three cycles of a pin change, or as a latched request that disappears before a clear.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

  // Field order follows the bit positions (bit 7 first).
  typedef struct packed {
    logic       conv_pwr;
    logic       clk_rc;
    logic       irq_fall;
    logic       start_dly;
    logic       mon_en;
    logic       mon_fast;
    logic [1:0] rate;
  } cfg_word_t;

  localparam logic [7:0] CFG_RESET   = 8'h10;
  localparam logic [7:0] CFG_GUARDED = 8'h37;

  // New register value for a write: free bits always follow wdata,
  // guarded bits follow wdata only when the guard is open.
  function automatic logic [7:0] cfg_merge(input logic [7:0] cur,
                                           input logic [7:0] wdata,
                                           input logic       guard_open);
    logic [7:0] g_src;
    g_src = guard_open ? wdata : cur;
    return (wdata & ~CFG_GUARDED) | (g_src & CFG_GUARDED);
  endfunction

endpackage

// File: rtl/cfg_window_guard.sv
module cfg_window_guard #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  output logic win_open,
  output logic locked
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

  logic [CNT_W-1:0] win_cnt;

  assign win_open = (win_cnt < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (win_open) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (wr_hit && win_open) begin
      locked <= 1'b1;
    end
  end

  // R3
  win_cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= LIMIT);
  // R3
  window_stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !win_open);
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import sys_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  input  logic       special_mode,
  input  logic       win_open,
  input  logic       locked,
  output logic [7:0] cfg_q
);
  logic guard_open;

  assign guard_open = special_mode | (win_open & ~locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_hit) begin
      cfg_q <= cfg_merge(cfg_q, wdata, guard_open);
    end
  end

  // R3
  guard_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && !win_open) |=> ((cfg_q & CFG_GUARDED) == $past(cfg_q & CFG_GUARDED)));
  // R4
  once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && locked) |=> ((cfg_q & CFG_GUARDED) == $past(cfg_q & CFG_GUARDED)));
  // R6
  free_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((cfg_q & ~CFG_GUARDED) == ($past(wdata) & ~CFG_GUARDED)));
  // R5
  special_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && special_mode) |=> (cfg_q == $past(wdata)));

endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic fall_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_n;
  logic                   sync_n;
  logic                   fall_evt;
  logic                   edge_latch;

  assign sync_n   = sync_q[SYNC_STAGES-1];
  assign fall_evt = prev_n & ~sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_n <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_n <= sync_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_latch <= 1'b0;
    end else if (fall_evt && fall_mode) begin
      edge_latch <= 1'b1;
    end else if (clr) begin
      edge_latch <= 1'b0;
    end
  end

  assign req = fall_mode ? edge_latch : ~sync_n;

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_latch && !clr) |=> edge_latch);
  // R8
  edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && fall_mode) |=> edge_latch);
  // R8
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fall_evt) |=> !edge_latch);

endmodule

// File: rtl/sys_cfg_guard.sv
module sys_cfg_guard
  import sys_cfg_pkg::*;
#(
  parameter int WINDOW      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_pin_n,
  input  logic       irq_clr,
  output logic       conv_pwr_en,
  output logic       clk_src_rc,
  output logic       irq_fall_mode,
  output logic       startup_dly_req,
  output logic       osc_bypass,
  output logic       clkmon_en,
  output logic       clkmon_fast,
  output logic [1:0] rate_sel,
  output logic       irq_req
);
  logic       wr_hit;
  logic       win_open;
  logic       locked;
  logic [7:0] cfg_q;
  cfg_word_t  cfg_w;

  assign wr_hit = bus_sel & bus_wr;

  cfg_window_guard #(.WINDOW(WINDOW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .win_open (win_open),
    .locked   (locked)
  );

  cfg_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_hit       (wr_hit),
    .wdata        (bus_wdata),
    .special_mode (special_mode),
    .win_open     (win_open),
    .locked       (locked),
    .cfg_q        (cfg_q)
  );

  assign cfg_w           = cfg_word_t'(cfg_q);
  assign bus_rdata       = cfg_q;
  assign conv_pwr_en     = cfg_w.conv_pwr;
  assign clk_src_rc      = cfg_w.clk_rc;
  assign irq_fall_mode   = cfg_w.irq_fall;
  assign startup_dly_req = cfg_w.start_dly;
  assign osc_bypass      = ~cfg_w.start_dly;
  assign clkmon_en       = cfg_w.mon_en;
  assign clkmon_fast     = cfg_w.mon_fast;
  assign rate_sel        = cfg_w.rate;

  irq_sense #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (irq_pin_n),
    .fall_mode (cfg_w.irq_fall),
    .clr       (irq_clr),
    .req       (irq_req)
  );

  // R7
  dly_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startup_dly_req != osc_bypass);
  // R10
  no_sel_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(bus_rdata));

endmodule

// File: tb/sys_cfg_guard_tb.sv
module sys_cfg_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_pin_n = 1'b1;
  logic       irq_clr = 1'b0;
  logic       conv_pwr_en, clk_src_rc, irq_fall_mode, startup_dly_req;
  logic       osc_bypass, clkmon_en, clkmon_fast, irq_req;
  logic [1:0] rate_sel;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // upper byte: write data, lower byte: expected readback once locked with 0x37 guarded
  localparam logic [15:0] VEC [8] = '{16'h0037, 16'hFFFF, 16'hC8FF, 16'h80B7,
                                      16'h4077, 16'h083F, 16'h3037, 16'hA5B7};

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_cfg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin_n(irq_pin_n), .irq_clr(irq_clr),
    .conv_pwr_en(conv_pwr_en), .clk_src_rc(clk_src_rc), .irq_fall_mode(irq_fall_mode),
    .startup_dly_req(startup_dly_req), .osc_bypass(osc_bypass), .clkmon_en(clkmon_en),
    .clkmon_fast(clkmon_fast), .rate_sel(rate_sel), .irq_req(irq_req)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Ends on the negedge at which reset is released; the next posedge is cycle 0.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    special_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Starts at a negedge, ends one negedge later with the write taken.
  task automatic bus_write(input logic [7:0] d, input logic sel);
    bus_sel = sel;
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2, R7 reset state
    do_reset();
    check8("R2 reset value", bus_rdata, 8'h10);
    check8("R7 dly after reset", {startup_dly_req, osc_bypass}, 8'h02);
    check8("R9 no irq after reset", {7'd0, irq_req}, 8'h00);

    // R3 first write inside the window is taken
    bus_write(8'hFF, 1'b1);
    check8("R3 write in window", bus_rdata, 8'hFF);
    // R4 second write: guarded bits keep their value, R10 full readback
    bus_write(8'h00, 1'b1);
    check8("R4 second write locked", bus_rdata, 8'h37);

    // R6 free bits through the vector table while locked
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][15:8], 1'b1);
      check8("R6 table readback", bus_rdata, VEC[i][7:0]);
    end

    // R3 window boundary: cycle 63 accepted
    do_reset();
    repeat (63) @(negedge clk);
    bus_write(8'h00, 1'b1);
    check8("R3 write at cycle 63", bus_rdata, 8'h00);

    // R3 window boundary: cycle 64 rejected for guarded bits
    do_reset();
    repeat (64) @(negedge clk);
    bus_write(8'h00, 1'b1);
    check8("R3 write at cycle 64", bus_rdata, 8'h10);

    // R3 long after the window
    do_reset();
    repeat (70) @(negedge clk);
    bus_write(8'hFF, 1'b1);
    check8("R3 write after window", bus_rdata, 8'hD8);

    // R5 special mode: repeated writes after the window
    special_mode = 1'b1;
    bus_write(8'hFF, 1'b1);
    check8("R5 special write 1", bus_rdata, 8'hFF);
    bus_write(8'h00, 1'b1);
    check8("R5 special write 2", bus_rdata, 8'h00);
    check8("R7 bypass when dly clear", {startup_dly_req, osc_bypass}, 8'h01);
    bus_write(8'hA5, 1'b1);
    check8("R5 special write 3", bus_rdata, 8'hA5);
    // R1 decode of 1010_0101
    check8("R1 decoded fields",
           {conv_pwr_en, clk_src_rc, irq_fall_mode, startup_dly_req,
            clkmon_en, clkmon_fast, rate_sel}, 8'hA5);
    // R10 strobe without select is ignored
    bus_write(8'h5A, 1'b0);
    check8("R10 write without select", bus_rdata, 8'hA5);

    // R8 edge mode (bit 5 set by 0xA5)
    irq_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check8("R8 edge not yet seen", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check8("R8 edge latched", {7'd0, irq_req}, 8'h01);
    irq_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    check8("R8 latch held after pin rise", {7'd0, irq_req}, 8'h01);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check8("R8 cleared", {7'd0, irq_req}, 8'h00);

    // R9 level mode
    bus_write(8'h00, 1'b1);
    irq_pin_n = 1'b0;
    @(negedge clk);
    check8("R9 level after one edge", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check8("R9 level after two edges", {7'd0, irq_req}, 8'h01);
    irq_pin_n = 1'b1;
    @(negedge clk);
    check8("R9 release after one edge", {7'd0, irq_req}, 8'h01);
    @(negedge clk);
    check8("R9 release after two edges", {7'd0, irq_req}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule